// File: doc/BRIEF.md
# Sticky-Preserving Mantissa Right Shifter

This block moves a 128-bit floating-point mantissa toward its least significant end by a requested count. It keeps a single sticky flag that records whether any nonzero bit was lost off the bottom. A rounding stage downstream uses that flag. The mantissa is held as four 32-bit words, and word 0 is the most significant. The block works in two steps. First it moves whole words down by the upper bits of the count. Then it slides the words across their boundaries by the low five bits of the count. Each step ORs the bits it discards into the sticky result. The incoming sticky flag is always merged in.

A count of zero is an illegal request. The block raises an error flag for it and passes the operand through unchanged. A count of 128 or more saturates: the mantissa becomes zero and the sticky flag becomes one. Each operation is framed by `in_valid`. The result appears on the registered outputs one clock later, together with `out_valid`. Rounding, exponent arithmetic and operand class handling live elsewhere.

Top module: `mant_sticky_shr`

## Requirements
- R1: The mantissa is 128 bits, and word 0 occupies bits 127:96. For a count n from 1 to 127 the output mantissa equals the input divided by 2^n, rounded toward zero.
- R2: A count of 0 sets `out_err` to 1. The output mantissa and sticky flag then equal the input mantissa and input sticky.
- R3: A count of 128 to 255 gives an all-zero output mantissa and an output sticky of 1, whatever the input sticky and mantissa. `out_err` stays 0.
- R4: For counts of 32 or more, whole words move down first. Any nonzero bit in a word that leaves the bottom sets the output sticky. For counts from 32 to 127 the top output word is zero.
- R5: The remaining 1 to 31 bit slide crosses word boundaries. Any nonzero bit slid out of the least significant word sets the output sticky.
- R6: The output sticky is the OR of the input sticky and every discarded bit, so an input sticky of 1 always gives an output sticky of 1.
- R7: For any count from 1 to 255, `out_err` is 0. With input sticky 0 and no nonzero bit discarded, the output sticky is 0.
- R8: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` high. Without `in_valid`, the result outputs hold their values.
- R9: A synchronous active-low reset clears `out_valid`, `out_err`, `out_sticky` and `out_mant` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation request this cycle |
| in_mant | input | 128 | Mantissa operand, word 0 in bits 127:96 |
| in_sticky | input | 1 | Sticky flag carried in with the operand |
| in_shift | input | 8 | Right-shift count; 0 is illegal, 128 and above saturate |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_mant | output | 128 | Shifted mantissa |
| out_sticky | output | 1 | Accumulated sticky flag |
| out_err | output | 1 | Illegal (zero) shift count was requested |

## Verification
The word move and the bit slide can both discard nonzero bits in the same operation, and both feed one sticky OR together with the incoming flag. Counts such as 33 provoke this. The bench pairs them with operands whose lost bits lie only in the dropped word, only in the bits slid out, or in neither. The output sticky is then judged against a single 128-bit reference shift with a mask of the lost bits. A sweep of every count from 1 to 140 over masked random operands also lands many cases where both steps discard bits at once.

// File: rtl/shr_pkg.sv
// Package: shared constants and flag type for the mantissa right shifter.
// Assumes: mantissa words are equal width and the word count is a power of two.
package shr_pkg;
    localparam int unsigned DEF_WORD_W = 32;
    localparam int unsigned DEF_WORDS  = 4;
    localparam int unsigned DEF_CNT_W  = 8;

    typedef struct packed {
        logic sticky;
        logic err;
    } shr_flag_t;
endpackage

// File: rtl/shr_word_move.sv
// Module: shr_word_move
// Moves whole words of the mantissa toward the low end by `sel` words.
// Words that fall off the bottom are OR-reduced into `lost`.
// Assumes: word 0 is the most significant word (top slice of the vector).
module shr_word_move #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned WORDS  = 4,
    parameter int unsigned SEL_W  = 2
) (
    input  logic [WORD_W*WORDS-1:0] in_mant,
    input  logic [SEL_W-1:0]        sel,
    output logic [WORD_W*WORDS-1:0] out_mant,
    output logic                    lost
);
    localparam int unsigned MANT_W = WORD_W * WORDS;

    // One multiplexer per destination word.
    for (genvar k = 0; k < WORDS; k++) begin : g_dst
        logic [WORD_W-1:0] pick;

        // Select the source word that lands in destination word k.
        always_comb begin
            pick = '0;
            for (int j = 0; j < WORDS; j++) begin
                if ((j + int'(sel)) == k) begin
                    pick = in_mant[MANT_W-1-j*WORD_W -: WORD_W];
                end
            end
        end

        assign out_mant[MANT_W-1-k*WORD_W -: WORD_W] = pick;
    end

    // OR together every word pushed off the low end.
    always_comb begin
        lost = 1'b0;
        for (int j = 0; j < WORDS; j++) begin
            if (j >= (int'(WORDS) - int'(sel))) begin
                lost = lost | (|in_mant[MANT_W-1-j*WORD_W -: WORD_W]);
            end
        end
    end
endmodule

// File: rtl/shr_bit_slide.sv
// Module: shr_bit_slide
// Slides the mantissa right by 0..WORD_W-1 bits across word boundaries.
// Bits leaving the least significant word are OR-reduced into `lost`.
// Assumes: word 0 is the most significant word; zeros fill from the top.
module shr_bit_slide #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned WORDS  = 4,
    parameter int unsigned AMT_W  = 5
) (
    input  logic [WORD_W*WORDS-1:0] in_mant,
    input  logic [AMT_W-1:0]        amt,
    output logic [WORD_W*WORDS-1:0] out_mant,
    output logic                    lost
);
    localparam int unsigned MANT_W = WORD_W * WORDS;

    // Each output word takes its high part from the word above it.
    for (genvar k = 0; k < WORDS; k++) begin : g_word
        logic [WORD_W-1:0]   upper;
        logic [2*WORD_W-1:0] pair;
        logic [2*WORD_W-1:0] slid;

        if (k == 0) begin : g_top
            assign upper = '0;
        end else begin : g_mid
            assign upper = in_mant[MANT_W-1-(k-1)*WORD_W -: WORD_W];
        end

        assign pair = {upper, in_mant[MANT_W-1-k*WORD_W -: WORD_W]};
        assign slid = pair >> amt;
        assign out_mant[MANT_W-1-k*WORD_W -: WORD_W] = slid[WORD_W-1:0];
    end

    logic [WORD_W-1:0] low_mask;

    // Flag any nonzero bit among the low `amt` bits of the bottom word.
    always_comb begin
        low_mask = (WORD_W'(1) << amt) - WORD_W'(1);
        lost     = |(in_mant[WORD_W-1:0] & low_mask);
    end
endmodule

// File: rtl/shr_out_stage.sv
// Module: shr_out_stage
// Optional result register. With REG_OUT=1 the result is captured on the
// cycle in_valid is high and held otherwise; with REG_OUT=0 it passes through.
// Assumes: synchronous active-low reset.
module shr_out_stage
    import shr_pkg::*;
#(
    parameter int unsigned MANT_W  = 128,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [MANT_W-1:0] d_mant,
    input  shr_flag_t         d_flag,
    output logic              q_valid,
    output logic [MANT_W-1:0] q_mant,
    output shr_flag_t         q_flag
);
    if (REG_OUT) begin : g_reg
        // Valid strobe follows the request by one cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) q_valid <= 1'b0;
            else        q_valid <= in_valid;
        end

        // Result captured on a request, held otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_mant <= '0;
                q_flag <= '0;
            end else if (in_valid) begin
                q_mant <= d_mant;
                q_flag <= d_flag;
            end
        end
    end else begin : g_comb
        assign q_valid = in_valid;
        assign q_mant  = d_mant;
        assign q_flag  = d_flag;
    end
endmodule

// File: rtl/mant_sticky_shr.sv
// Module: mant_sticky_shr (top)
// Right-shifts a multi-word mantissa by in_shift and accumulates a sticky
// flag from every discarded bit and the incoming sticky. Whole-word moves
// come first, then a sub-word slide. Count 0 is flagged illegal and passes
// the operand through; counts at or above the mantissa width saturate to
// zero with sticky set.
// Assumes: CNT_W can express the mantissa width (saturation reachable).
module mant_sticky_shr
    import shr_pkg::*;
#(
    parameter int unsigned WORD_W  = DEF_WORD_W,
    parameter int unsigned WORDS   = DEF_WORDS,
    parameter int unsigned CNT_W   = DEF_CNT_W,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [WORD_W*WORDS-1:0] in_mant,
    input  logic                    in_sticky,
    input  logic [CNT_W-1:0]        in_shift,
    output logic                    out_valid,
    output logic [WORD_W*WORDS-1:0] out_mant,
    output logic                    out_sticky,
    output logic                    out_err
);
    localparam int unsigned MANT_W = WORD_W * WORDS;
    localparam int unsigned BIT_W  = $clog2(WORD_W);
    localparam int unsigned SEL_W  = $clog2(WORDS);
    localparam int unsigned IDX_W  = BIT_W + SEL_W;

    logic [BIT_W-1:0]  bit_amt;
    logic [SEL_W-1:0]  word_sel;
    logic              saturate;
    logic              illegal;
    logic [MANT_W-1:0] moved;
    logic [MANT_W-1:0] slid;
    logic              word_lost;
    logic              bit_lost;
    logic [MANT_W-1:0] d_mant;
    shr_flag_t         d_flag;
    shr_flag_t         q_flag;

    assign bit_amt  = in_shift[BIT_W-1:0];
    assign word_sel = in_shift[BIT_W +: SEL_W];
    assign illegal  = (in_shift == '0);

    // Any count bit above the index range means the shift clears everything.
    if (CNT_W > IDX_W) begin : g_sat
        assign saturate = |in_shift[CNT_W-1:IDX_W];
    end else begin : g_nosat
        assign saturate = 1'b0;
    end

    shr_word_move #(
        .WORD_W(WORD_W),
        .WORDS (WORDS),
        .SEL_W (SEL_W)
    ) u_word (
        .in_mant (in_mant),
        .sel     (word_sel),
        .out_mant(moved),
        .lost    (word_lost)
    );

    shr_bit_slide #(
        .WORD_W(WORD_W),
        .WORDS (WORDS),
        .AMT_W (BIT_W)
    ) u_bit (
        .in_mant (moved),
        .amt     (bit_amt),
        .out_mant(slid),
        .lost    (bit_lost)
    );

    // Choose between pass-through, saturation and the normal shifted result.
    always_comb begin
        if (illegal) begin
            d_mant        = in_mant;
            d_flag.sticky = in_sticky;
            d_flag.err    = 1'b1;
        end else if (saturate) begin
            d_mant        = '0;
            d_flag.sticky = 1'b1;
            d_flag.err    = 1'b0;
        end else begin
            d_mant        = slid;
            d_flag.sticky = in_sticky | word_lost | bit_lost;
            d_flag.err    = 1'b0;
        end
    end

    shr_out_stage #(
        .MANT_W (MANT_W),
        .REG_OUT(REG_OUT)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .d_mant  (d_mant),
        .d_flag  (d_flag),
        .q_valid (out_valid),
        .q_mant  (out_mant),
        .q_flag  (q_flag)
    );

    assign out_sticky = q_flag.sticky;
    assign out_err    = q_flag.err;
endmodule

// File: rtl/shr_checker.sv
// Module: shr_checker
// Temporal properties of mant_sticky_shr, attached by bind below.
// Assumes: properties apply only to the registered-output variant.
module shr_checker #(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned WORDS   = 4,
    parameter int unsigned CNT_W   = 8,
    parameter bit          REG_OUT = 1'b1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [WORD_W*WORDS-1:0] in_mant,
    input logic                    in_sticky,
    input logic [CNT_W-1:0]        in_shift,
    input logic                    out_valid,
    input logic [WORD_W*WORDS-1:0] out_mant,
    input logic                    out_sticky,
    input logic                    out_err
);
    localparam int unsigned MANT_W = WORD_W * WORDS;

    if (REG_OUT) begin : g_props
        assert_zero_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_shift == '0) |=>
            (out_err && out_mant == $past(in_mant) && out_sticky == $past(in_sticky)));

        assert_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_shift >= CNT_W'(MANT_W)) |=>
            (out_mant == '0 && out_sticky && !out_err));

        assert_top_word_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_shift >= CNT_W'(WORD_W) && in_shift < CNT_W'(MANT_W)) |=>
            (out_mant[MANT_W-1 -: WORD_W] == '0));

        assert_sticky_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_sticky) |=> out_sticky);

        assert_legal_no_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_shift != '0) |=> !out_err);

        assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);

        assert_valid_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> (!out_valid && $stable(out_mant) && $stable(out_sticky)));

        assert_reset_clear_R9: assert property (@(posedge clk)
            !rst_n |=> (!out_valid && !out_err && !out_sticky && out_mant == '0));
    end
endmodule

bind mant_sticky_shr shr_checker #(
    .WORD_W (WORD_W),
    .WORDS  (WORDS),
    .CNT_W  (CNT_W),
    .REG_OUT(REG_OUT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mant   (in_mant),
    .in_sticky (in_sticky),
    .in_shift  (in_shift),
    .out_valid (out_valid),
    .out_mant  (out_mant),
    .out_sticky(out_sticky),
    .out_err   (out_err)
);

// File: tb/sim_mant_sticky_shr.sv
`timescale 1ns/1ps
module sim_mant_sticky_shr;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [127:0] in_mant;
    logic         in_sticky;
    logic [7:0]   in_shift;
    logic         out_valid;
    logic [127:0] out_mant;
    logic         out_sticky;
    logic         out_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mant_sticky_shr u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_mant   (in_mant),
        .in_sticky (in_sticky),
        .in_shift  (in_shift),
        .out_valid (out_valid),
        .out_mant  (out_mant),
        .out_sticky(out_sticky),
        .out_err   (out_err)
    );

    // Vector: [265:258] count, [257] sticky in, [256:129] mantissa,
    // [128:1] expected mantissa, [0] expected sticky.
    localparam logic [265:0] VEC [0:10] = '{
        {8'd1,   1'b0, 128'h8000_0000_0000_0000_0000_0000_0000_0000, 128'h4000_0000_0000_0000_0000_0000_0000_0000, 1'b0},
        {8'd1,   1'b0, 128'h1,                                      128'h0,                                      1'b1},
        {8'd32,  1'b0, 128'h0000_0001_0000_0000_0000_0000_0000_0000, 128'h0000_0000_0000_0001_0000_0000_0000_0000, 1'b0},
        {8'd96,  1'b0, 128'h5,                                      128'h0,                                      1'b1},
        {8'd128, 1'b0, {128{1'b1}},                                 128'h0,                                      1'b1},
        {8'd127, 1'b0, 128'h8000_0000_0000_0000_0000_0000_0000_0000, 128'h1,                                      1'b0},
        {8'd4,   1'b1, 128'hF0,                                     128'hF,                                      1'b1},
        {8'd4,   1'b0, 128'h10,                                     128'h1,                                      1'b0},
        {8'd64,  1'b0, 128'hDEAD_BEEF_0000_0000_0000_0000_0000_0000, 128'h0000_0000_0000_0000_DEAD_BEEF_0000_0000, 1'b0},
        {8'd255, 1'b0, 128'h0,                                      128'h0,                                      1'b1},
        {8'd36,  1'b0, 128'hA000_0000_0000_0000_0000_0000_0000_0000, 128'h0000_0000_0A00_0000_0000_0000_0000_0000, 1'b0}
    };

    // Reference: one wide shift plus a mask of the bits it discards.
    function automatic logic [128:0] ref_shr(logic [127:0] m, logic s, logic [7:0] n);
        logic [127:0] lost_mask;
        if (n == 8'd0)   return {m, s};
        if (n >= 8'd128) return {128'h0, 1'b1};
        lost_mask = ~({128{1'b1}} << n);
        return {m >> n, s | (|(m & lost_mask))};
    endfunction

    task automatic chk_mant(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s mant act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk_bit(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%b exp=%b", req, what, act, exp);
        end
    endtask

    // One request; returns at the negedge after the capturing posedge.
    task automatic issue(logic [127:0] m, logic s, logic [7:0] n);
        @(negedge clk);
        in_mant = m; in_sticky = s; in_shift = n; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic issue_ref(string req, logic [127:0] m, logic s, logic [7:0] n);
        logic [128:0] e;
        e = ref_shr(m, s, n);
        issue(m, s, n);
        chk_mant(req, out_mant, e[128:1]);
        chk_bit(req, "sticky", out_sticky, e[0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [127:0] m;
        logic [127:0] held;
        rst_n = 1'b0; in_valid = 1'b0; in_mant = '0; in_sticky = 1'b0; in_shift = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk_bit("R9", "valid", out_valid, 1'b0);
        chk_bit("R9", "err", out_err, 1'b0);
        chk_bit("R9", "sticky", out_sticky, 1'b0);
        chk_mant("R9", out_mant, 128'h0);
        rst_n = 1'b1;

        // R1: table of directed vectors
        for (int i = 0; i < 11; i++) begin
            issue(VEC[i][256:129], VEC[i][257], VEC[i][265:258]);
            chk_mant("R1", out_mant, VEC[i][128:1]);
            chk_bit("R1", "sticky", out_sticky, VEC[i][0]);
            chk_bit("R1", "err", out_err, 1'b0);
        end

        // R4 / R5: every count 1..140 on masked random operands
        for (int n = 1; n <= 140; n++) begin
            for (int r = 0; r < 3; r++) begin
                m = {$urandom, $urandom, $urandom, $urandom};
                if (r == 1) m[63:0] = '0;
                if (r == 2) m = m & {4{32'h8000_0001}};
                issue_ref((n % 32 == 0) ? "R4" : "R5", m, r == 2, 8'(n));
            end
        end

        // R4 + R5 together at count 33: lost word only, lost bit only, neither
        issue_ref("R4", 128'h1, 1'b0, 8'd33);
        chk_bit("R4", "sticky", out_sticky, 1'b1);
        issue_ref("R5", 128'h1_0000_0000, 1'b0, 8'd33);
        chk_bit("R5", "sticky", out_sticky, 1'b1);
        issue_ref("R7", 128'h2_0000_0000, 1'b0, 8'd33);
        chk_bit("R7", "sticky", out_sticky, 1'b0);
        chk_mant("R7", out_mant, 128'h1);

        // R2: zero count flags error and passes operand through
        issue(128'h1234_5678_9ABC_DEF0_0F0F_F0F0_AAAA_5555, 1'b1, 8'd0);
        chk_bit("R2", "err", out_err, 1'b1);
        chk_bit("R2", "sticky", out_sticky, 1'b1);
        chk_mant("R2", out_mant, 128'h1234_5678_9ABC_DEF0_0F0F_F0F0_AAAA_5555);
        issue(128'h8, 1'b0, 8'd2);
        chk_bit("R7", "err", out_err, 1'b0);
        chk_bit("R7", "sticky", out_sticky, 1'b0);

        // R3: saturation ignores operand and sticky in
        issue({128{1'b1}}, 1'b0, 8'd200);
        chk_mant("R3", out_mant, 128'h0);
        chk_bit("R3", "sticky", out_sticky, 1'b1);
        chk_bit("R3", "err", out_err, 1'b0);

        // R6: sticky in kept when nothing is lost
        issue(128'h100, 1'b1, 8'd4);
        chk_bit("R6", "sticky", out_sticky, 1'b1);
        chk_mant("R6", out_mant, 128'h10);

        // R8: valid timing and hold while idle
        @(negedge clk);
        in_mant = 128'hC0; in_sticky = 1'b0; in_shift = 8'd6; in_valid = 1'b1;
        chk_bit("R8", "valid before edge", out_valid, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        chk_bit("R8", "valid", out_valid, 1'b1);
        held = out_mant;
        chk_mant("R8", held, 128'h3);
        in_mant = {128{1'b1}}; in_shift = 8'd1; in_sticky = 1'b1;
        repeat (3) @(negedge clk);
        chk_bit("R8", "valid idle", out_valid, 1'b0);
        chk_mant("R8", out_mant, held);
        chk_bit("R8", "sticky idle", out_sticky, 1'b0);

        // R9: synchronous reset mid-run clears outputs
        issue({128{1'b1}}, 1'b1, 8'd0);
        rst_n = 1'b0;
        @(negedge clk);
        chk_bit("R9", "err", out_err, 1'b0);
        chk_bit("R9", "sticky", out_sticky, 1'b0);
        chk_mant("R9", out_mant, 128'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule